// File: doc/BRIEF.md
# Four-Lane Gain Shift, Round and Saturate Scaler

This block narrows four parallel lanes of full-precision 32-bit signed products (30 fractional bits) down to 16-bit signed samples with 15 fractional bits. Each lane is first multiplied by a power of two chosen at run time. The result is then rounded to the nearest output step, with ties going to the even code. Last, it is clipped to a range that is symmetric about zero. Rounding to even and symmetric clipping both keep a DC offset out of the narrowed stream. Each lane reports when its value had to be clipped.

The gain is held in a small register that software writes over a simple memory-mapped write port. The register value selects an entry of a four-entry shift table. The table is a parameter and by default holds the left shifts 0, 1, 2 and 3. The register can be written but not read back. A sample valid strobe and a channel tag travel alongside the data and leave with the same one-cycle delay as the lanes.

Top module: `lane_gain_scaler`

## Requirements
- R1: Each output lane equals the input lane, read as signed with 30 fractional bits, times 2^shift and rounded to 15 fractional bits. The result is a signed 16-bit code.
- R2: Rounding drops the 15 low bits of the shifted value. Remainders above one half round up and remainders below one half round down. An exact half (dropped bits equal to 0x4000) goes to the even result.
- R3: Rounded results above +32767 give 0x7FFF and results below -32767 give 0x8001. The code 0x8000 is never output.
- R4: out_sat[k] is 1 exactly when lane k of a valid sample was clipped under R3. It is 0 whenever out_valid is 0.
- R5: The gain register is cleared to 0 by reset. It loads wr_data[1:0] on a clock edge where wr_en is 1, wr_addr equals 0x10 and wr_be[0] is 1.
- R6: A write to another address, or one with wr_be[0] at 0, leaves the gain register unchanged. Bits above bit 1 of wr_data have no effect on the gain.
- R7: Gain value g selects shift table entry g, which by default is a left shift by g. A write acts on samples presented in later cycles. A sample presented in the same cycle as a write still uses the old gain.
- R8: The four lanes are scaled independently. Lane k sits in bits [32k+31:32k] of in_lanes and in bits [16k+15:16k] of out_lanes.
- R9: out_valid and out_tag follow in_valid and in_tag after exactly one clock cycle. Output lanes change only when a valid sample is captured.
- R10: During and right after reset, out_valid, out_tag, out_lanes and out_sat are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample strobe |
| in_tag | input | 8 | Channel tag of the input sample |
| in_lanes | input | 128 | Four signed 32-bit lanes, lane 0 in the low bits |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 8 | Bus write address |
| wr_be | input | 4 | Bus byte enables |
| wr_data | input | 32 | Bus write data |
| out_valid | output | 1 | Output sample strobe |
| out_tag | output | 8 | Channel tag of the output sample |
| out_lanes | output | 64 | Four signed 16-bit lanes, lane 0 in the low bits |
| out_sat | output | 4 | Per-lane clip flags |

## Verification
Directed samples whose dropped bits are exactly one half, with both even and odd kept parts, separate round-to-even from round-half-up and from truncation. Values at and just past both limits, including the exact most negative product, check whether clipping is symmetric and whether the flags fire at the right point. Writes to the wrong address, writes with the low byte disabled, and a write in the same cycle as a sample show when the gain changes. Random samples in four magnitude classes are mixed with random gain writes. They test the shift table and lane order across all gains, and carry a distinct tag in each cycle so that a slip in latency is caught.

// File: rtl/lgs_pkg.sv
package lgs_pkg;

   // Number of bits needed to encode shift amounts 0..max_shift.
   function automatic int unsigned shift_bits(input int unsigned max_shift);
      int unsigned b;
      b = 1;
      while ((1 << b) <= max_shift) b++;
      return b;
   endfunction

   // Default shift table: entry g shifts left by g (entry 0 in the low bits).
   localparam int unsigned DEF_GAIN_W    = 2;
   localparam int unsigned DEF_MAX_SHIFT = 3;

endpackage

// File: rtl/lgs_gain_reg.sv
module lgs_gain_reg #(
   parameter int unsigned          ADDR_W    = 8,
   parameter int unsigned          DATA_W    = 32,
   parameter int unsigned          GAIN_W    = 2,
   parameter logic [ADDR_W-1:0]    GAIN_ADDR = 8'h10
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [DATA_W/8-1:0]     wr_be,
   input  logic [DATA_W-1:0]       wr_data,
   output logic [GAIN_W-1:0]       gain_q
);

   localparam int unsigned BE_W = DATA_W / 8;

   if (GAIN_W > 8) begin : g_bad_gain_w
      $error("lgs_gain_reg: gain field must fit in the low byte");
   end
   if (DATA_W % 8 != 0) begin : g_bad_data_w
      $error("lgs_gain_reg: data width must be a multiple of 8");
   end

   logic hit;
   assign hit = wr_en && (wr_addr == GAIN_ADDR) && wr_be[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gain_q <= '0;
      end else if (hit) begin
         gain_q <= wr_data[GAIN_W-1:0];
      end
   end

   logic unused_bits;
   assign unused_bits = ^{wr_data[DATA_W-1:GAIN_W], wr_be[BE_W-1:0]};

endmodule

// File: rtl/lgs_lane_scale.sv
module lgs_lane_scale #(
   parameter int unsigned IN_W      = 32,
   parameter int unsigned OUT_W     = 16,
   parameter int unsigned DROP      = 15,
   parameter int unsigned MAX_SHIFT = 3,
   parameter int unsigned SH_W      = 2
) (
   input  logic [IN_W-1:0]  din,
   input  logic [SH_W-1:0]  shift,
   output logic [OUT_W-1:0] dout,
   output logic             sat
);

   localparam int unsigned EXT_W  = IN_W + MAX_SHIFT;
   localparam int unsigned KEEP_W = EXT_W - DROP;
   localparam int unsigned RND_W  = KEEP_W + 1;

   if (KEEP_W < OUT_W) begin : g_bad_keep
      $error("lgs_lane_scale: too many bits dropped for the output width");
   end
   if (OUT_W > 31) begin : g_bad_out_w
      $error("lgs_lane_scale: output width above 31 not supported");
   end

   localparam logic signed [RND_W-1:0] POS_LIM = RND_W'((64'd1 << (OUT_W - 1)) - 64'd1);
   localparam logic signed [RND_W-1:0] NEG_LIM = -POS_LIM;

   logic signed [EXT_W-1:0]  ext;
   logic signed [EXT_W-1:0]  shifted;
   logic signed [KEEP_W-1:0] kept;
   logic signed [RND_W-1:0]  rnd;

   assign ext     = {{MAX_SHIFT{din[IN_W-1]}}, din};
   assign shifted = ext <<< shift;
   assign kept    = shifted[EXT_W-1:DROP];

   if (DROP == 0) begin : g_no_round
      assign rnd = {kept[KEEP_W-1], kept};
   end else begin : g_round_even
      localparam logic [DROP-1:0] HALF = DROP'(64'd1 << (DROP - 1));
      logic [DROP-1:0] frac;
      logic            up;
      assign frac = shifted[DROP-1:0];
      assign up   = (frac > HALF) || ((frac == HALF) && kept[0]);
      assign rnd  = {kept[KEEP_W-1], kept} + {{KEEP_W{1'b0}}, up};
   end

   logic over, under;
   assign over  = rnd > POS_LIM;
   assign under = rnd < NEG_LIM;
   assign sat   = over || under;

   always_comb begin
      if (over)       dout = POS_LIM[OUT_W-1:0];
      else if (under) dout = NEG_LIM[OUT_W-1:0];
      else            dout = rnd[OUT_W-1:0];
   end

endmodule

// File: rtl/lane_gain_scaler.sv
module lane_gain_scaler
   import lgs_pkg::*;
#(
   parameter int unsigned       LANES     = 4,
   parameter int unsigned       IN_W      = 32,
   parameter int unsigned       IN_FRAC   = 30,
   parameter int unsigned       OUT_W     = 16,
   parameter int unsigned       TAG_W     = 8,
   parameter int unsigned       ADDR_W    = 8,
   parameter int unsigned       DATA_W    = 32,
   parameter int unsigned       GAIN_W    = DEF_GAIN_W,
   parameter int unsigned       MAX_SHIFT = DEF_MAX_SHIFT,
   parameter logic [ADDR_W-1:0] GAIN_ADDR = 8'h10,
   parameter logic [(1<<GAIN_W)*shift_bits(MAX_SHIFT)-1:0] SHIFT_TAB = 8'b11_10_01_00
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic [TAG_W-1:0]       in_tag,
   input  logic [LANES*IN_W-1:0]  in_lanes,
   input  logic                   wr_en,
   input  logic [ADDR_W-1:0]      wr_addr,
   input  logic [DATA_W/8-1:0]    wr_be,
   input  logic [DATA_W-1:0]      wr_data,
   output logic                   out_valid,
   output logic [TAG_W-1:0]       out_tag,
   output logic [LANES*OUT_W-1:0] out_lanes,
   output logic [LANES-1:0]       out_sat
);

   localparam int unsigned OUT_FRAC = OUT_W - 1;
   localparam int unsigned DROP     = IN_FRAC - OUT_FRAC;
   localparam int unsigned SH_W     = shift_bits(MAX_SHIFT);
   localparam int unsigned TAB_N    = 1 << GAIN_W;

   // Elaboration-time parameter checks
   if (LANES < 1) begin : g_bad_lanes
      $error("lane_gain_scaler: at least one lane required");
   end
   if (IN_FRAC < OUT_FRAC || IN_FRAC >= IN_W) begin : g_bad_frac
      $error("lane_gain_scaler: input fraction must cover the output fraction");
   end
   if (MAX_SHIFT < 1) begin : g_bad_shift
      $error("lane_gain_scaler: maximum shift must be at least 1");
   end
   for (genvar t = 0; t < TAB_N; t++) begin : g_tab_chk
      if (SHIFT_TAB[t*SH_W +: SH_W] > MAX_SHIFT) begin : g_bad_entry
         $error("lane_gain_scaler: shift table entry exceeds maximum shift");
      end
   end

   // Gain register and shift lookup
   logic [GAIN_W-1:0] gain_q;
   logic [SH_W-1:0]   cur_shift;

   lgs_gain_reg #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .GAIN_W    (GAIN_W),
      .GAIN_ADDR (GAIN_ADDR)
   ) gain_reg_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_be   (wr_be),
      .wr_data (wr_data),
      .gain_q  (gain_q)
   );

   assign cur_shift = SHIFT_TAB[gain_q*SH_W +: SH_W];

   // Per-lane datapath and output register
   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [OUT_W-1:0] scaled;
      logic             clip;

      lgs_lane_scale #(
         .IN_W      (IN_W),
         .OUT_W     (OUT_W),
         .DROP      (DROP),
         .MAX_SHIFT (MAX_SHIFT),
         .SH_W      (SH_W)
      ) scale_i (
         .din   (in_lanes[k*IN_W +: IN_W]),
         .shift (cur_shift),
         .dout  (scaled),
         .sat   (clip)
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_lanes[k*OUT_W +: OUT_W] <= '0;
            out_sat[k]                  <= 1'b0;
         end else begin
            out_sat[k] <= in_valid && clip;
            if (in_valid) begin
               out_lanes[k*OUT_W +: OUT_W] <= scaled;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_tag   <= '0;
      end else begin
         out_valid <= in_valid;
         out_tag   <= in_tag;
      end
   end

endmodule

// File: rtl/lane_gain_scaler_chk.sv
module lane_gain_scaler_chk #(
   parameter int unsigned       LANES     = 4,
   parameter int unsigned       OUT_W     = 16,
   parameter int unsigned       TAG_W     = 8,
   parameter int unsigned       ADDR_W    = 8,
   parameter int unsigned       DATA_W    = 32,
   parameter int unsigned       GAIN_W    = 2,
   parameter logic [ADDR_W-1:0] GAIN_ADDR = 8'h10
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   in_valid,
   input logic [TAG_W-1:0]       in_tag,
   input logic                   wr_en,
   input logic [ADDR_W-1:0]      wr_addr,
   input logic [DATA_W/8-1:0]    wr_be,
   input logic [DATA_W-1:0]      wr_data,
   input logic                   out_valid,
   input logic [TAG_W-1:0]       out_tag,
   input logic [LANES*OUT_W-1:0] out_lanes,
   input logic [LANES-1:0]       out_sat,
   input logic [GAIN_W-1:0]      gain_q
);

   localparam logic [OUT_W-1:0] MOST_NEG = {1'b1, {(OUT_W-1){1'b0}}};
   localparam logic [OUT_W-1:0] POS_CLIP = {1'b0, {(OUT_W-1){1'b1}}};
   localparam logic [OUT_W-1:0] NEG_CLIP = {1'b1, {(OUT_W-2){1'b0}}, 1'b1};

   logic gain_hit;
   assign gain_hit = wr_en && (wr_addr == GAIN_ADDR) && wr_be[0];

   assert_valid_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_idle_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   assert_tag_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_tag == $past(in_tag));
   assert_sat_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> out_sat == '0);
   assert_gain_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      gain_hit |=> gain_q == $past(wr_data[GAIN_W-1:0]));
   assert_gain_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !gain_hit |=> $stable(gain_q));

   for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
      assert_no_most_neg_R3: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> out_lanes[k*OUT_W +: OUT_W] != MOST_NEG);
      assert_sat_at_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
         out_sat[k] |-> (out_lanes[k*OUT_W +: OUT_W] == POS_CLIP ||
                         out_lanes[k*OUT_W +: OUT_W] == NEG_CLIP));
      assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> $stable(out_lanes[k*OUT_W +: OUT_W]));
   end

endmodule

bind lane_gain_scaler lane_gain_scaler_chk #(
   .LANES     (LANES),
   .OUT_W     (OUT_W),
   .TAG_W     (TAG_W),
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .GAIN_W    (GAIN_W),
   .GAIN_ADDR (GAIN_ADDR)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_tag    (in_tag),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .wr_be     (wr_be),
   .wr_data   (wr_data),
   .out_valid (out_valid),
   .out_tag   (out_tag),
   .out_lanes (out_lanes),
   .out_sat   (out_sat),
   .gain_q    (gain_q)
);

// File: tb/lane_gain_scaler_tb_top.sv
module lane_gain_scaler_tb_top;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic [7:0]        in_tag = '0;
   logic [3:0][31:0]  in_d = '0;
   logic              wr_en = 1'b0;
   logic [7:0]        wr_addr = '0;
   logic [3:0]        wr_be = '0;
   logic [31:0]       wr_data = '0;
   logic              out_valid;
   logic [7:0]        out_tag;
   logic [63:0]       out_lanes;
   logic [3:0]        out_sat;

   int checks = 0;
   int errors = 0;
   int mgain  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   lane_gain_scaler dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_tag    (in_tag),
      .in_lanes  (in_d),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_be     (wr_be),
      .wr_data   (wr_data),
      .out_valid (out_valid),
      .out_tag   (out_tag),
      .out_lanes (out_lanes),
      .out_sat   (out_sat)
   );

   // Reference: {sat, code} for one lane under shift s (R1, R2, R3)
   function automatic logic [16:0] model(input logic [31:0] x, input int s);
      longint v, k, f;
      v = longint'($signed(x)) <<< s;
      k = v >>> 15;
      f = v & 64'h7FFF;
      if (f > 64'h4000 || (f == 64'h4000 && (k & 1) != 0)) k = k + 1;
      if (k > 32767)  return {1'b1, 16'h7FFF};
      if (k < -32767) return {1'b1, 16'h8001};
      return {1'b0, k[15:0]};
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // One cycle: drive at negedge, design captures at posedge, check at next negedge.
   task automatic step(input bit v, input logic [3:0][31:0] d, input logic [7:0] tag,
                       input bit we, input logic [7:0] a, input logic [3:0] be,
                       input logic [31:0] wd, input string req);
      logic [3:0][16:0] exp;
      in_valid = v; in_d = d; in_tag = tag;
      wr_en = we; wr_addr = a; wr_be = be; wr_data = wd;
      for (int k = 0; k < 4; k++) exp[k] = model(d[k], mgain);
      @(negedge clk);
      wr_en = 1'b0;
      in_valid = 1'b0;
      check(out_valid == v, "R9", "out_valid", longint'(out_valid), longint'(v));
      if (v) begin
         check(out_tag == tag, "R9", "out_tag", longint'(out_tag), longint'(tag));
         for (int k = 0; k < 4; k++) begin
            check(out_lanes[16*k +: 16] == exp[k][15:0], req, $sformatf("lane %0d (R8)", k),
                  longint'(out_lanes[16*k +: 16]), longint'(exp[k][15:0]));
            check(out_sat[k] == exp[k][16], "R4", $sformatf("sat %0d", k),
                  longint'(out_sat[k]), longint'(exp[k][16]));
         end
      end else begin
         check(out_sat == 4'h0, "R4", "sat while idle", longint'(out_sat), 0);
      end
      if (we && a == 8'h10 && be[0]) mgain = int'(wd[1:0]);
   endtask

   task automatic sample(input logic [3:0][31:0] d, input string req);
      step(1'b1, d, 8'($urandom), 1'b0, 8'h00, 4'h0, 32'h0, req);
   endtask

   task automatic write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] wd);
      step(1'b0, '0, 8'h00, 1'b1, a, be, wd, "R5");
   endtask

   function automatic logic [31:0] rnd_lane();
      logic [31:0] r;
      r = $urandom;
      case ($urandom % 4)
         0: return r;
         1: return 32'($signed(r[21:0]));
         2: return {r[31], {3{~r[31]}}, r[27:0]};
         default: return {r[31:15], 15'h4000};
      endcase
   endfunction

   initial begin
      int cyc;
      cyc = 0;
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      logic [3:0][31:0] d;
      void'($urandom(32'd20250611));
      repeat (3) @(negedge clk);
      // R10: reset state
      check(out_valid == 1'b0, "R10", "out_valid", longint'(out_valid), 0);
      check(out_tag == 8'h0, "R10", "out_tag", longint'(out_tag), 0);
      check(out_lanes == 64'h0, "R10", "out_lanes", longint'(out_lanes), 0);
      check(out_sat == 4'h0, "R10", "out_sat", longint'(out_sat), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_lanes == 64'h0, "R10", "out_lanes after reset", longint'(out_lanes), 0);

      // R1, R2: ties to even, above and below half, gain 0
      d = {32'h0000_4000, 32'h0000_C000, 32'hFFFF_C000, 32'h0000_4001};
      sample(d, "R2");
      d = {32'hFFFF_4000, 32'h0000_3FFF, 32'h1234_5678, 32'hEDCB_A987};
      sample(d, "R1");
      // R3: limits, exact most negative, just inside
      d = {32'h7FFF_FFFF, 32'h8000_0000, 32'hC000_0000, 32'h3FFF_8000};
      sample(d, "R3");
      d = {32'h3FFF_C000, 32'hC000_4000, 32'hC000_8000, 32'h3FFF_BFFF};
      sample(d, "R3");

      // R5, R7: gain 1 doubles
      write(8'h10, 4'h1, 32'h0000_0001);
      d = {32'h2000_0000, 32'h1FFF_C000, 32'hE000_0000, 32'h0000_2000};
      sample(d, "R7");
      // R6: wrong address, low byte disabled, upper bits ignored
      write(8'h14, 4'hF, 32'h0000_0003);
      sample(d, "R6");
      write(8'h10, 4'hE, 32'hFFFF_FFFE);
      sample(d, "R6");
      write(8'h10, 4'h1, 32'hFFFF_FFFC);
      sample(d, "R6");
      // R7: write and sample in the same cycle use the old gain, next uses new
      step(1'b1, d, 8'h5A, 1'b1, 8'h10, 4'h1, 32'h3, "R7");
      sample(d, "R7");
      // R9: idle gap keeps valid low
      step(1'b0, '0, 8'h00, 1'b0, 8'h00, 4'h0, 32'h0, "R9");

      // Random mix with random gain writes
      for (int i = 0; i < 400; i++) begin
         for (int k = 0; k < 4; k++) d[k] = rnd_lane();
         case ($urandom % 8)
            0: step(1'b1, d, 8'(i), 1'b1, 8'h10, 4'($urandom), $urandom, "R7");
            1: step(1'b0, d, 8'(i), 1'b0, 8'h00, 4'h0, 32'h0, "R9");
            default: step(1'b1, d, 8'(i), 1'b0, 8'h00, 4'h0, 32'h0, "R1");
         endcase
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule